// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Overflow Policy

This unit turns an IEEE 754 double-precision operand into a signed or unsigned integer of 32 or 64 bits. The answer always comes back in a 64-bit result. A 3-bit mode field picks one of three policies for NaN and out-of-range inputs:

- saturate, with NaN giving the type minimum;
- saturate, with NaN giving zero;
- modulo-wrap, with NaN and infinity giving zero.

The low mode bit forces truncation. When it is clear, the rounding direction comes from a 2-bit status rounding field. A 2-bit type field selects the integer format.

Alongside the result the unit reports a write enable and a set of per-operation flags: inexact, fraction-rounded, invalid-conversion, signaling-NaN invalid, overflow, summary overflow and exception summary. In record mode it also reports four condition bits. The datapath is combinational and feeds one output register stage.

Sequencing is a two-state machine. The unit starts in `ST_IDLE`. The transition `GO` (input valid) moves it to `ST_RESULT` and captures one conversion. In `ST_RESULT`, `GO` captures another conversion and stays there, while `DRAIN` (input valid low) returns to `ST_IDLE`. The output valid is high exactly in `ST_RESULT`.

Top module: `f2i_conv`

## Requirements
- R1: Type field encoding: bit 0 set means unsigned and bit 1 set means 64-bit, so 0 = signed 32, 1 = unsigned 32, 2 = signed 64, 3 = unsigned 64. A signed 32-bit result is sign-extended from bit 31 to 64 bits; an unsigned 32-bit result is zero-extended.
- R2: Rounding is truncation toward zero when mode bit 0 is 1 or the rounding field is 01. Otherwise rounding field 00 rounds to nearest with ties to even, 10 rounds toward +infinity and 11 rounds toward -infinity.
- R3: Under modes 000 to 011, a rounded value above the type maximum gives the maximum and a value below the type minimum gives the minimum. Infinities count as out of range.
- R4: A NaN gives the type minimum under modes 000/001 (0x8000000000000000 for signed 64, 0xFFFFFFFF80000000 for signed 32, 0 for unsigned) and gives 0 under modes 010/011.
- R5: Under modes 100/101, NaN, infinity or a magnitude of at least 2^128 gives 0. Any other rounded value is taken modulo 2^32 or 2^64 as a two's-complement bit pattern, then extended as in R1.
- R6: A conversion is invalid when the source is NaN or the rounded value lies outside the type range. An invalid conversion sets the invalid-conversion flag and clears inexact and fraction-rounded. Overflow and summary overflow are set only for an invalid conversion with overflow-enable at 1.
- R7: For a valid conversion, inexact is 1 when the rounded result differs from the source value. Fraction-rounded is 1 when the result's magnitude exceeds the source's magnitude.
- R8: When the invalid-exception enable is 1 and the conversion is invalid, write enable is 0 and the result output is 0. Otherwise a legal conversion has write enable 1.
- R9: A signaling NaN (exponent all ones, nonzero fraction, fraction bit 51 clear) sets the signaling-NaN flag as well as invalid-conversion. The exception summary bit is 1 when invalid-conversion or inexact is set.
- R10: With record mode on, condition bits [3:1] are negative, positive and zero of the written 64-bit result read as signed, and bit 0 copies summary overflow. When nothing is written, bits [3:1] are 0. With record mode off, all four bits are 0.
- R11: Modes 110 and 111 raise the illegal output and give write enable 0, result 0, condition bits 0 and every exception flag 0.
- R12: Reset clears every output. A conversion presented with input valid appears on the outputs, with output valid high, after the next rising clock edge. Output valid falls one edge after input valid falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| in_operand | input | 64 | Double-precision source bits |
| in_mode | input | 3 | Policy and rounding-source select |
| in_type | input | 2 | Integer format select |
| in_rn | input | 2 | Status rounding-mode field |
| in_inv_en | input | 1 | Invalid-exception enable |
| in_ov_en | input | 1 | Overflow-enable bit |
| in_record | input | 1 | Record mode, produces condition bits |
| out_valid | output | 1 | Registered outputs hold a conversion |
| out_result | output | 64 | Integer result |
| out_wr_en | output | 1 | Destination write enable |
| out_illegal | output | 1 | Illegal mode indication |
| out_inexact | output | 1 | Inexact flag |
| out_frac_rnd | output | 1 | Fraction-rounded flag |
| out_inv_cvt | output | 1 | Invalid-conversion flag |
| out_inv_snan | output | 1 | Signaling-NaN invalid flag |
| out_ov | output | 1 | Overflow |
| out_so | output | 1 | Summary overflow |
| out_fx | output | 1 | Exception summary |
| out_cr | output | 4 | Condition bits {neg, pos, zero, so} |

## Verification
Some relations between flags are checked by assertions on every cycle:

- inexact and fraction-rounded never accompany an invalid conversion;
- fraction-rounded implies inexact;
- a signaling NaN always carries invalid-conversion;
- an illegal mode is silent;
- a blocked write has a zero result;
- at most one condition sign bit is set.

Only the bench's scenarios can show that the actual integer is right. These cover each rounding direction on halfway and subnormal inputs, saturation exactly at and just past the 32- and 64-bit limits, and the modulo value of large in-range magnitudes. They are compared against a model built on real arithmetic, across all modes and types.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    typedef enum logic [1:0] {
        RM_NEAR  = 2'd0,
        RM_TRUNC = 2'd1,
        RM_CEIL  = 2'd2,
        RM_FLOOR = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        POL_SAT_MIN  = 2'd0,
        POL_SAT_ZERO = 2'd1,
        POL_WRAP     = 2'd2,
        POL_BAD      = 2'd3
    } policy_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } conv_state_e;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output logic                  sign,
    output logic                  is_nan,
    output logic                  is_snan,
    output logic                  is_inf,
    output logic [EXP_W-1:0]      exp_eff,
    output logic [FRAC_W:0]       mant
);
    logic [EXP_W-1:0]  exp_raw;
    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              exp_zero;

    always_comb begin
        sign     = operand[EXP_W+FRAC_W];
        exp_raw  = operand[EXP_W+FRAC_W-1:FRAC_W];
        frac     = operand[FRAC_W-1:0];
        exp_ones = &exp_raw;
        exp_zero = (exp_raw == '0);
        is_nan   = exp_ones & (|frac);
        is_snan  = is_nan & ~frac[FRAC_W-1];
        is_inf   = exp_ones & (frac == '0);
        // subnormals share the scale of the smallest normal exponent
        exp_eff  = exp_zero ? EXP_W'(1) : exp_raw;
        mant     = {~exp_zero, frac};
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int MAG_W  = 129
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_eff,
    input  logic [FRAC_W:0]   mant,
    input  rmode_e            rmode,
    output logic [MAG_W-1:0]  mag,
    output logic              big,
    output logic              inexact,
    output logic              incr
);
    localparam int MANT_W  = FRAC_W + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int INT_POS = BIAS + FRAC_W;       // mantissa lsb weighs exactly 1
    localparam int BIG_EXP = BIAS + MAG_W - 1;    // magnitude reaches 2^(MAG_W-1)
    localparam int GRD_W   = FRAC_W + 3;
    localparam int EXT_W   = MANT_W + GRD_W;
    localparam int MAX_RSH = GRD_W - 1;

    int                e_i;
    logic [EXT_W-1:0]  ext;
    logic [MANT_W-1:0] ipart;
    logic              guard;
    logic              sticky;

    always_comb begin
        e_i    = int'(exp_eff);
        ext    = '0;
        ipart  = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        big    = 1'b0;
        mag    = '0;
        if (e_i >= BIG_EXP) begin
            big = 1'b1;
        end else if (e_i >= INT_POS) begin
            mag = MAG_W'(mant) << (e_i - INT_POS);
        end else if ((INT_POS - e_i) > MAX_RSH) begin
            // below one quarter: only sticky information survives
            sticky = |mant;
        end else begin
            ext    = {mant, {GRD_W{1'b0}}} >> (INT_POS - e_i);
            ipart  = ext[EXT_W-1:GRD_W];
            guard  = ext[GRD_W-1];
            sticky = |ext[GRD_W-2:0];
        end

        inexact = guard | sticky;
        unique case (rmode)
            RM_NEAR:  incr = guard & (sticky | ipart[0]);
            RM_TRUNC: incr = 1'b0;
            RM_CEIL:  incr = ~sign & inexact;
            RM_FLOOR: incr = sign & inexact;
        endcase

        if (!big && (e_i < INT_POS)) begin
            mag = MAG_W'(ipart) + MAG_W'(incr);
        end
    end
endmodule

// File: rtl/f2i_policy.sv
module f2i_policy
    import f2i_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int MAG_W = 129
) (
    input  policy_e           policy,
    input  logic [1:0]        itype,
    input  logic              sign,
    input  logic              is_nan,
    input  logic              is_inf,
    input  logic              big,
    input  logic [MAG_W-1:0]  mag,
    output logic [XLEN-1:0]   result,
    output logic              invalid
);
    localparam int HW = XLEN / 2;

    logic             uns;
    logic             wide;
    int               w;
    logic [MAG_W-1:0] one_m;
    logic [MAG_W-1:0] max_mag;
    logic [MAG_W-1:0] neg_mag;
    logic             over;
    logic             under;
    logic [XLEN-1:0]  max_v;
    logic [XLEN-1:0]  min_v;
    logic [XLEN-1:0]  wrapped;
    logic [XLEN-1:0]  raw;

    always_comb begin
        uns     = itype[0];
        wide    = itype[1];
        w       = wide ? XLEN : HW;
        one_m   = MAG_W'(1);
        max_mag = (one_m << (uns ? w : (w - 1))) - one_m;
        neg_mag = uns ? '0 : (one_m << (w - 1));
        over    = ~is_nan & ~sign & (is_inf | big | (mag > max_mag));
        under   = ~is_nan &  sign & (is_inf | big | (mag > neg_mag));
        invalid = is_nan | over | under;

        max_v   = max_mag[XLEN-1:0];
        min_v   = uns ? '0 : -(XLEN'(1) << (w - 1));
        wrapped = sign ? -mag[XLEN-1:0] : mag[XLEN-1:0];

        unique case (policy)
            POL_SAT_MIN: begin
                if (is_nan)     raw = min_v;
                else if (over)  raw = max_v;
                else if (under) raw = min_v;
                else            raw = wrapped;
            end
            POL_SAT_ZERO: begin
                if (is_nan)     raw = '0;
                else if (over)  raw = max_v;
                else if (under) raw = min_v;
                else            raw = wrapped;
            end
            POL_WRAP: begin
                if (is_nan || is_inf || big) raw = '0;
                else                         raw = wrapped;
            end
            POL_BAD: raw = '0;
        endcase

        if (wide)     result = raw;
        else if (uns) result = {{HW{1'b0}}, raw[HW-1:0]};
        else          result = {{HW{raw[HW-1]}}, raw[HW-1:0]};
    end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int XLEN   = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   in_operand,
    input  logic [2:0]              in_mode,
    input  logic [1:0]              in_type,
    input  logic [1:0]              in_rn,
    input  logic                    in_inv_en,
    input  logic                    in_ov_en,
    input  logic                    in_record,
    output logic                    out_valid,
    output logic [XLEN-1:0]         out_result,
    output logic                    out_wr_en,
    output logic                    out_illegal,
    output logic                    out_inexact,
    output logic                    out_frac_rnd,
    output logic                    out_inv_cvt,
    output logic                    out_inv_snan,
    output logic                    out_ov,
    output logic                    out_so,
    output logic                    out_fx,
    output logic [3:0]              out_cr
);
    localparam int MAG_W = 2 * XLEN + 1;

    // ---------------- datapath ----------------
    logic              u_sign, u_nan, u_snan, u_inf;
    logic [EXP_W-1:0]  u_exp;
    logic [FRAC_W:0]   u_mant;
    rmode_e            rmode;
    policy_e           policy;
    logic [MAG_W-1:0]  r_mag;
    logic              r_big, r_inexact, r_incr;
    logic [XLEN-1:0]   p_result;
    logic              p_invalid;

    f2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .operand (in_operand),
        .sign    (u_sign),
        .is_nan  (u_nan),
        .is_snan (u_snan),
        .is_inf  (u_inf),
        .exp_eff (u_exp),
        .mant    (u_mant)
    );

    always_comb begin
        if (in_mode[0] || in_rn == 2'b01) rmode = RM_TRUNC;
        else                              rmode = rmode_e'(in_rn);
        policy = policy_e'(in_mode[2:1]);
    end

    f2i_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .MAG_W(MAG_W)) u_round (
        .sign    (u_sign),
        .exp_eff (u_exp),
        .mant    (u_mant),
        .rmode   (rmode),
        .mag     (r_mag),
        .big     (r_big),
        .inexact (r_inexact),
        .incr    (r_incr)
    );

    f2i_policy #(.XLEN(XLEN), .MAG_W(MAG_W)) u_policy (
        .policy  (policy),
        .itype   (in_type),
        .sign    (u_sign),
        .is_nan  (u_nan),
        .is_inf  (u_inf),
        .big     (r_big),
        .mag     (r_mag),
        .result  (p_result),
        .invalid (p_invalid)
    );

    logic            c_illegal, c_inv, c_snan, c_xx, c_fr, c_block, c_wr, c_ovf;
    logic [XLEN-1:0] c_res;
    logic [3:0]      c_cr;

    always_comb begin
        c_illegal = (policy == POL_BAD);
        c_inv     = ~c_illegal & p_invalid;
        c_snan    = ~c_illegal & u_snan;
        c_xx      = ~c_illegal & ~p_invalid & r_inexact;
        c_fr      = ~c_illegal & ~p_invalid & r_incr;
        c_block   = in_inv_en & c_inv;
        c_wr      = ~c_illegal & ~c_block;
        c_res     = c_wr ? p_result : '0;
        c_ovf     = c_inv & in_ov_en;
        if (in_record)
            c_cr = {c_wr & c_res[XLEN-1],
                    c_wr & ~c_res[XLEN-1] & (c_res != '0),
                    c_wr & (c_res == '0),
                    c_ovf};
        else
            c_cr = 4'b0000;
    end

    // ---------------- sequencing ----------------
    conv_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nxt = in_valid ? ST_RESULT : ST_IDLE;    // GO
            ST_RESULT: state_nxt = in_valid ? ST_RESULT : ST_IDLE;    // GO / DRAIN
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result   <= '0;
            out_wr_en    <= 1'b0;
            out_illegal  <= 1'b0;
            out_inexact  <= 1'b0;
            out_frac_rnd <= 1'b0;
            out_inv_cvt  <= 1'b0;
            out_inv_snan <= 1'b0;
            out_ov       <= 1'b0;
            out_so       <= 1'b0;
            out_fx       <= 1'b0;
            out_cr       <= 4'b0000;
        end else if (in_valid) begin
            out_result   <= c_res;
            out_wr_en    <= c_wr;
            out_illegal  <= c_illegal;
            out_inexact  <= c_xx;
            out_frac_rnd <= c_fr;
            out_inv_cvt  <= c_inv;
            out_inv_snan <= c_snan;
            out_ov       <= c_ovf;
            out_so       <= c_ovf;
            out_fx       <= c_inv | c_xx;
            out_cr       <= c_cr;
        end
    end

    assign out_valid = (state == ST_RESULT);

    // ---------------- assertions ----------------
    assert_inv_clears_round_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_inv_cvt |-> (!out_inexact && !out_frac_rnd));

    assert_ov_needs_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_ov |-> out_inv_cvt);

    assert_fr_implies_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_frac_rnd |-> out_inexact);

    assert_blocked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wr_en && !out_illegal) |-> (out_inv_cvt && out_result == '0));

    assert_snan_is_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_inv_snan |-> out_inv_cvt);

    assert_cr_sign_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_cr[3:1]));

    assert_illegal_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_wr_en && !out_inv_cvt && !out_inexact && !out_fx && out_cr == 4'b0000));

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drains_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: tb/f2i_conv_tb.sv
`timescale 1ns/1ps
module f2i_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [2:0]  in_mode = '0;
    logic [1:0]  in_type = '0;
    logic [1:0]  in_rn = '0;
    logic        in_inv_en = 1'b0;
    logic        in_ov_en = 1'b0;
    logic        in_record = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_wr_en, out_illegal, out_inexact, out_frac_rnd, out_inv_cvt;
    logic        out_inv_snan, out_ov, out_so, out_fx;
    logic [3:0]  out_cr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    f2i_conv u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_mode(in_mode), .in_type(in_type), .in_rn(in_rn), .in_inv_en(in_inv_en),
        .in_ov_en(in_ov_en), .in_record(in_record), .out_valid(out_valid),
        .out_result(out_result), .out_wr_en(out_wr_en), .out_illegal(out_illegal),
        .out_inexact(out_inexact), .out_frac_rnd(out_frac_rnd), .out_inv_cvt(out_inv_cvt),
        .out_inv_snan(out_inv_snan), .out_ov(out_ov), .out_so(out_so), .out_fx(out_fx),
        .out_cr(out_cr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    localparam real P63  = 9223372036854775808.0;
    localparam real P64  = 18446744073709551616.0;
    localparam real P128 = 340282366920938463463374607431768211456.0;

    // Drives at the current falling edge, checks at the next falling edge.
    task automatic run_one(input logic [63:0] op, input logic [2:0] md, input logic [1:0] ty,
                           input logic [1:0] rn, input logic ie, input logic oe, input logic rc);
        logic sg, nan, snan, inf, big64, big128, inx, inc, trunc, uns, ill;
        logic over, under, inv, wr, xx, fr, so;
        real a, fpart;
        logic [63:0] fl, minv, maxv, sv, raw, res;
        logic [64:0] R, maxm, negm, one65;
        logic [3:0] cr;
        int w, sh;
        string rtag;

        in_operand = op; in_mode = md; in_type = ty; in_rn = rn;
        in_inv_en = ie; in_ov_en = oe; in_record = rc; in_valid = 1'b1;

        sg   = op[63];
        nan  = (op[62:52] == 11'h7ff) && (op[51:0] != 0);
        snan = nan && !op[51];
        inf  = (op[62:52] == 11'h7ff) && (op[51:0] == 0);
        ill  = (md[2:1] == 2'b11);
        uns  = ty[0];
        w    = ty[1] ? 64 : 32;
        a = 0.0; fpart = 0.0; R = '0; inx = 0; inc = 0; fl = '0;
        big64 = inf; big128 = inf;
        if (!nan && !inf) begin
            a = $bitstoreal({1'b0, op[62:0]});
            big64  = (a >= P64);
            big128 = (a >= P128);
            if (!big64) begin
                if (a >= P63) begin
                    fl = 64'h8000_0000_0000_0000 + 64'(longint'(a - P63));
                    fpart = 0.0;
                end else begin
                    fl = 64'(longint'(a));
                    if (real'(fl) > a) fl = fl - 64'd1;
                    fpart = a - real'(fl);
                end
                trunc = md[0] || (rn == 2'b01);
                inx = (fpart != 0.0);
                if (trunc) inc = 0;
                else if (rn == 2'b00) inc = (fpart > 0.5) || (fpart == 0.5 && fl[0]);
                else if (rn == 2'b10) inc = !sg && inx;
                else inc = sg && inx;
                R = {1'b0, fl} + {64'b0, inc};
            end
        end
        one65 = 65'd1;
        maxm  = (one65 << (uns ? w : w - 1)) - one65;
        negm  = uns ? 65'd0 : (one65 << (w - 1));
        over  = !nan && !sg && (big64 || R > maxm);
        under = !nan &&  sg && (big64 || R > negm);
        inv   = nan || over || under;
        maxv  = maxm[63:0];
        minv  = uns ? 64'd0 : ((w == 32) ? 64'hFFFF_FFFF_8000_0000 : 64'h8000_0000_0000_0000);
        sv    = sg ? -R[63:0] : R[63:0];

        rtag = "R2";
        case (md[2:1])
            2'b00: begin raw = nan ? minv : over ? maxv : under ? minv : sv; if (nan) rtag = "R4"; else if (over || under) rtag = "R3"; end
            2'b01: begin raw = nan ? 64'd0 : over ? maxv : under ? minv : sv; if (nan) rtag = "R4"; else if (over || under) rtag = "R3"; end
            2'b10: begin
                rtag = "R5";
                if (nan || inf || big128) raw = 64'd0;
                else if (!big64) raw = sv;
                else begin
                    sh = int'(op[62:52]) - 1075;
                    raw = (sh >= 64) ? 64'd0 : ({11'b0, 1'b1, op[51:0]} << sh);
                    if (sg) raw = -raw;
                end
            end
            default: raw = 64'd0;
        endcase
        if (w == 32) begin
            raw = uns ? {32'b0, raw[31:0]} : {{32{raw[31]}}, raw[31:0]};
            if (!inv && md[2:1] != 2'b10) rtag = "R1";
        end

        if (ill) begin
            rtag = "R11"; wr = 0; res = 0; inv = 0; snan = 0; xx = 0; fr = 0; so = 0; cr = 0;
        end else begin
            wr  = !(ie && inv);
            res = wr ? raw : 64'd0;
            xx  = !inv && inx;
            fr  = !inv && inc;
            so  = inv && oe;
            cr  = rc ? {wr && res[63], wr && !res[63] && res != 0, wr && res == 0, so} : 4'b0;
        end

        @(negedge clk);
        chk("R12 out_valid", {63'b0, out_valid}, 64'd1);
        chk({rtag, " result"}, out_result, res);
        chk("R8 wr_en", {63'b0, out_wr_en}, {63'b0, wr});
        chk("R11 illegal", {63'b0, out_illegal}, {63'b0, ill});
        chk("R6 inv_cvt", {63'b0, out_inv_cvt}, {63'b0, inv});
        chk("R7 inexact", {63'b0, out_inexact}, {63'b0, xx});
        chk("R7 frac_rnd", {63'b0, out_frac_rnd}, {63'b0, fr});
        chk("R9 inv_snan", {63'b0, out_inv_snan}, {63'b0, snan});
        chk("R9 fx", {63'b0, out_fx}, {63'b0, inv || xx});
        chk("R6 ov", {63'b0, out_ov}, {63'b0, so});
        chk("R6 so", {63'b0, out_so}, {63'b0, so});
        chk("R10 cr", {60'b0, out_cr}, {60'b0, cr});
    endtask

    logic [63:0] ops [35];

    initial begin
        ops[0]  = 64'h0000_0000_0000_0000;
        ops[1]  = 64'h8000_0000_0000_0000;
        ops[2]  = 64'h0000_0000_0000_0001;
        ops[3]  = 64'h8000_0000_0000_0001;
        ops[4]  = $realtobits(0.5);
        ops[5]  = $realtobits(-0.5);
        ops[6]  = $realtobits(1.5);
        ops[7]  = $realtobits(2.5);
        ops[8]  = $realtobits(-2.5);
        ops[9]  = $realtobits(0.75);
        ops[10] = $realtobits(-1.25);
        ops[11] = $realtobits(2147483647.0);
        ops[12] = $realtobits(2147483647.5);
        ops[13] = $realtobits(2147483648.0);
        ops[14] = $realtobits(-2147483648.0);
        ops[15] = $realtobits(-2147483648.5);
        ops[16] = $realtobits(-2147483649.0);
        ops[17] = $realtobits(4294967295.0);
        ops[18] = $realtobits(4294967295.5);
        ops[19] = $realtobits(4294967296.0);
        ops[20] = $realtobits(-1.0);
        ops[21] = $realtobits(9223372036854775808.0);
        ops[22] = $realtobits(-9223372036854775808.0);
        ops[23] = $realtobits(18446744073709549568.0);
        ops[24] = $realtobits(18446744073709551616.0);
        ops[25] = $realtobits(1.0e30);
        ops[26] = $realtobits(-1.0e30);
        ops[27] = $realtobits(340282366920938463463374607431768211456.0);
        ops[28] = 64'h7FF0_0000_0000_0000;
        ops[29] = 64'hFFF0_0000_0000_0000;
        ops[30] = 64'h7FF8_0000_0000_0000;
        ops[31] = 64'h7FF0_0000_0000_0001;
        ops[32] = $realtobits(3.5);
        ops[33] = $realtobits(4503599627370495.5);
        ops[34] = $realtobits(-9223372036854774784.0);

        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset valid", {63'b0, out_valid}, 64'd0);
        chk("R12 reset result", out_result, 64'd0);
        chk("R12 reset cr", {60'b0, out_cr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        begin
            int k;
            k = 0;
            for (int md = 0; md < 8; md++)
                for (int ty = 0; ty < 4; ty++)
                    for (int rn = 0; rn < 4; rn++)
                        for (int i = 0; i < 35; i++) begin
                            run_one(ops[i], 3'(md), 2'(ty), 2'(rn), k[1], k[2], k[0] | k[3]);
                            k++;
                        end
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R12 valid drains", {63'b0, out_valid}, 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule